// File: doc/BRIEF.md
# Word-Aligned Serial Converter Host

This block is the host side of a link to a 10-bit serial analog-to-digital converter whose port moves data in fixed-size words of either 4 or 8 bits, chosen by the `XFER_W` parameter. For each exchange it lowers chip select and generates a serial clock divided down from the system clock. It shifts out a request of whole words that carries leading zeros, a start bit and three configuration bits. It then reads back enough whole words to cover the result. The start bit sits just far enough into the request that the returned bits arrive already left justified, with the converter's trailing zeros in the low positions, so no shifting is needed after the read.

With 8-bit words the request is one word and the reply is two words. With 4-bit words the request is two words and the reply is three words. In both cases the request occupies 8 serial clocks. It consists of four zeros, then the start bit (a one), then the single/differential select, the odd/sign select and the MSB-first select, in that order. The first reply bit (B9) is sampled on the rising serial clock that follows the last request bit.

In single-wire mode the host output and the converter output share one line. The host stops driving the line as soon as its last request bit has been clocked in, which is half a serial period before the converter starts driving. The 16-bit result is presented with a one-cycle valid strobe. A busy flag covers the whole exchange.

Top module: `adc_word_host`

## Requirements
- R1: While reset is held, and after it is released, `cs_n_o` is 1 and `sclk_o`, `busy_o`, `valid_o` and `mosi_oe_o` are 0.
- R2: On the first 8 rising edges of `sclk_o` in a frame, `mosi_o` carries, in this order: 0, 0, 0, 0, 1, `sgl_i`, `odd_i`, `msbf_i`.
- R3: One frame has exactly 8 + RSP_BITS rising edges of `sclk_o` while `cs_n_o` is low. RSP_BITS is the whole number of `XFER_W`-bit words needed to hold 10 bits: 16 for 8-bit words and 12 for 4-bit words.
- R4: `result_o[15]` holds the bit sampled on rising edge 9 of the frame (B9). Each following result bit holds the next sampled bit. With 4-bit words, `result_o[3:0]` is 0.
- R5: Values on `miso_i` during the first 8 rising edges have no effect on `result_o`.
- R6: In single-wire mode, `mosi_oe_o` drops to 0 on the 8th rising edge of `sclk_o` and stays 0 for the rest of the frame, so it is never high while the converter drives. In four-wire mode, `mosi_oe_o` stays 1 for the whole frame.
- R7: `cs_n_o` is low from the cycle after an accepted start until the frame ends. `sclk_o` is 0 whenever `cs_n_o` is 1.
- R8: Every half period of `sclk_o` within a frame, including the interval from `cs_n_o` falling to the first rising edge, lasts `div_i`+1 system clock cycles.
- R9: `busy_o` rises in the cycle after `start_i` is accepted. `valid_o` pulses for one cycle in which `busy_o` is already 0. A `start_i` seen while busy is ignored.
- R10: `sgl_i`, `odd_i`, `msbf_i`, `one_wire_i` and `div_i` are captured at the accepted start. Changing them during a frame does not alter that frame.
- R11: A `start_i` presented in the same cycle as `valid_o` is accepted and starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin one exchange when idle |
| sgl_i | input | 1 | Single-ended (1) or differential (0) select sent in the request |
| odd_i | input | 1 | Odd/sign select sent in the request |
| msbf_i | input | 1 | MSB-first select sent in the request |
| one_wire_i | input | 1 | 1 when the data-in and data-out lines are joined |
| div_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| busy_o | output | 1 | Exchange in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| result_o | output | 16 | Left-justified result, B9 in bit 15 |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Request data to the converter |
| mosi_oe_o | output | 1 | Drive enable for `mosi_o` |
| miso_i | input | 1 | Reply data from the converter |

## Verification
Two events can fall in the same cycle: the end of one frame, marked by `valid_o` with `busy_o` low, and the acceptance of a new `start_i`. The bench provokes this by waiting for the valid strobe and raising `start_i` in that same cycle with a new configuration and new converter data. It then requires both the finished result and the following frame's request, length and result to match. A start pulse in the middle of a busy frame, with every configuration input changed at the same time, checks that a frame already running is neither restarted nor altered.

// File: rtl/adc_word_host_pkg.sv
// Shared constants and types for the word-aligned converter host.
// Assumes a converter that returns a 10-bit result MSB first.
package adc_word_host_pkg;
    localparam int RES_BITS  = 10;  // converter result width
    localparam int CMD_BITS  = 4;   // start bit plus three configuration bits
    localparam int LEAD_BITS = 4;   // minimum zeros ahead of the start bit

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic sgl;
        logic odd;
        logic msbf;
    } req_cfg_t;
endpackage

// File: rtl/adc_word_host_sclk.sv
// Serial clock divider. While enabled it toggles sclk every div_i+1
// system clocks and flags, one cycle early, the edge it is about to make.
// Assumes div_i is held stable while enabled. Idles low when disabled.
module adc_word_host_sclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             term;

    // Terminal count marks the cycle whose closing edge toggles sclk.
    assign term   = en_i && (cnt_q == div_i);
    assign rise_o = term && !sclk_q;
    assign fall_o = term && sclk_q;
    assign sclk_o = sclk_q;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (term) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_word_host_seq.sv
// Frame sequencer. Counts rising serial clock edges, owns chip select,
// and tells the shifters when to load, capture, release and finish.
// Assumes rise_i/fall_i only pulse while the frame is running.
module adc_word_host_seq
    import adc_word_host_pkg::*;
#(
    parameter int REQ_BITS = 8,
    parameter int RSP_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic busy_o,
    output logic cs_n_o,
    output logic load_o,
    output logic capture_o,
    output logic release_o,
    output logic finish_o
);
    localparam int TOT_BITS = REQ_BITS + RSP_BITS;
    localparam int CNT_W    = $clog2(TOT_BITS + 1);
    localparam logic [CNT_W-1:0] TOT_C  = CNT_W'(TOT_BITS);
    localparam logic [CNT_W-1:0] REQ_C  = CNT_W'(REQ_BITS);
    localparam logic [CNT_W-1:0] LAST_Q = CNT_W'(REQ_BITS - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] edge_q;
    logic             cs_n_q;
    logic             run;

    // Decode of the frame events from state and edge count.
    assign run       = (state_q == SEQ_RUN);
    assign load_o    = !run && start_i;
    assign finish_o  = run && fall_i && (edge_q == TOT_C);
    assign capture_o = run && rise_i && (edge_q >= REQ_C);
    assign release_o = run && rise_i && (edge_q == LAST_Q);
    assign busy_o    = run;
    assign cs_n_o    = cs_n_q;

    // Frame state, chip select and rising-edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            edge_q  <= '0;
            cs_n_q  <= 1'b1;
        end else if (load_o) begin
            state_q <= SEQ_RUN;
            edge_q  <= '0;
            cs_n_q  <= 1'b0;
        end else if (finish_o) begin
            state_q <= SEQ_IDLE;
            cs_n_q  <= 1'b1;
        end else if (run && rise_i) begin
            edge_q  <= edge_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_word_host_tx.sv
// Request shifter and line-direction control. Loads zeros, start bit and
// configuration at the start and shifts one bit per falling serial edge.
// In single-wire mode it releases the line at the last request bit.
module adc_word_host_tx
    import adc_word_host_pkg::*;
#(
    parameter int REQ_BITS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  req_cfg_t cfg_i,
    input  logic     one_wire_i,
    input  logic     fall_i,
    input  logic     release_i,
    input  logic     finish_i,
    output logic     mosi_o,
    output logic     oe_o
);
    localparam int PAD_BITS = REQ_BITS - CMD_BITS;

    logic [REQ_BITS-1:0] shift_q;
    logic                oe_q;

    assign mosi_o = shift_q[REQ_BITS-1];
    assign oe_o   = oe_q;

    // Request shift register, MSB presented first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (load_i) begin
            shift_q <= {{PAD_BITS{1'b0}}, 1'b1, cfg_i.sgl, cfg_i.odd, cfg_i.msbf};
        end else if (fall_i) begin
            shift_q <= {shift_q[REQ_BITS-2:0], 1'b0};
        end
    end

    // Drive enable: on for the frame, dropped early when the line is shared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (load_i) begin
            oe_q <= 1'b1;
        end else if (finish_i) begin
            oe_q <= 1'b0;
        end else if (release_i && one_wire_i) begin
            oe_q <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_word_host_rx.sv
// Reply shifter. Shifts in reply bits MSB first and, at the end of the
// frame, presents them left justified with a one-cycle valid strobe.
// Assumes RSP_BITS <= OUT_W.
module adc_word_host_rx #(
    parameter int RSP_BITS = 16,
    parameter int OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             capture_i,
    input  logic             finish_i,
    input  logic             miso_i,
    output logic [OUT_W-1:0] result_o,
    output logic             valid_o
);
    logic [RSP_BITS-1:0] shift_q;
    logic [OUT_W-1:0]    aligned;
    logic [OUT_W-1:0]    result_q;
    logic                valid_q;

    // Alignment: pad below the reply only when it is narrower than the output.
    generate
        if (RSP_BITS == OUT_W) begin : g_full
            assign aligned = shift_q;
        end else begin : g_pad
            assign aligned = {shift_q, {(OUT_W - RSP_BITS){1'b0}}};
        end
    endgenerate

    assign result_o = result_q;
    assign valid_o  = valid_q;

    // Reply shift register, cleared at the start of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            shift_q <= '0;
        end else if (capture_i) begin
            shift_q <= {shift_q[RSP_BITS-2:0], miso_i};
        end
    end

    // Result hold register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= finish_i;
            if (finish_i) begin
                result_q <= aligned;
            end
        end
    end
endmodule

// File: rtl/adc_word_host.sv
// Word-aligned serial converter host, top level. Sizes request and reply
// to whole XFER_W-bit words, latches the configuration at start and ties
// the clock divider, sequencer and shifters together.
// Assumes XFER_W divides into a request of at least 8 bits.
module adc_word_host
    import adc_word_host_pkg::*;
#(
    parameter int XFER_W = 8,
    parameter int DIV_W  = 8,
    parameter int OUT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sgl_i,
    input  logic             odd_i,
    input  logic             msbf_i,
    input  logic             one_wire_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] result_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             mosi_oe_o,
    input  logic             miso_i
);
    localparam int REQ_WORDS = (LEAD_BITS + CMD_BITS + XFER_W - 1) / XFER_W;
    localparam int RSP_WORDS = (RES_BITS + XFER_W - 1) / XFER_W;
    localparam int REQ_BITS  = REQ_WORDS * XFER_W;
    localparam int RSP_BITS  = RSP_WORDS * XFER_W;

    req_cfg_t         cfg_live;
    logic             ow_q;
    logic [DIV_W-1:0] div_q;
    logic             rise, fall;
    logic             load, capture, release_line, finish;
    logic             run;

    assign cfg_live = '{sgl: sgl_i, odd: odd_i, msbf: msbf_i};
    assign busy_o   = run;

    // Per-frame capture of line mode and divide ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ow_q  <= 1'b0;
            div_q <= '0;
        end else if (load) begin
            ow_q  <= one_wire_i;
            div_q <= div_i;
        end
    end

    adc_word_host_sclk #(.DIV_W(DIV_W)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (run),
        .div_i  (div_q),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    adc_word_host_seq #(.REQ_BITS(REQ_BITS), .RSP_BITS(RSP_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rise_i    (rise),
        .fall_i    (fall),
        .busy_o    (run),
        .cs_n_o    (cs_n_o),
        .load_o    (load),
        .capture_o (capture),
        .release_o (release_line),
        .finish_o  (finish)
    );

    adc_word_host_tx #(.REQ_BITS(REQ_BITS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .cfg_i      (cfg_live),
        .one_wire_i (ow_q),
        .fall_i     (fall),
        .release_i  (release_line),
        .finish_i   (finish),
        .mosi_o     (mosi_o),
        .oe_o       (mosi_oe_o)
    );

    adc_word_host_rx #(.RSP_BITS(RSP_BITS), .OUT_W(OUT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .capture_i (capture),
        .finish_i  (finish),
        .miso_i    (miso_i),
        .result_o  (result_o),
        .valid_o   (valid_o)
    );
endmodule

// File: rtl/adc_word_host_chk.sv
// Protocol checker for the converter host, bound to every instance of the
// top. Tracks serial edges and half periods with its own counters.
module adc_word_host_chk #(
    parameter int DIV_W    = 8,
    parameter int REQ_BITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             valid_o,
    input logic             cs_n_o,
    input logic             sclk_o,
    input logic             mosi_oe_o,
    input logic             one_wire_q,
    input logic [DIV_W-1:0] div_q
);
    logic           sclk_d;
    logic [7:0]     rise_cnt;
    logic [DIV_W:0] hp_cnt;

    // Delayed clock, rising-edge count and half-period length per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
            hp_cnt   <= '0;
        end else begin
            sclk_d <= sclk_o;
            if (cs_n_o) begin
                rise_cnt <= '0;
                hp_cnt   <= '0;
            end else begin
                if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
                if (sclk_o != sclk_d) hp_cnt <= 1;
                else                  hp_cnt <= hp_cnt + 1'b1;
            end
        end
    end

    p_idle_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    p_busy_selects_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !cs_n_o);

    p_valid_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!busy_o && $past(busy_o)));

    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    p_line_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && one_wire_q && (rise_cnt >= 8'(REQ_BITS))) |-> !mosi_oe_o);

    p_half_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && (sclk_o != sclk_d)) |-> (hp_cnt == ({1'b0, div_q} + 1'b1)));
endmodule

bind adc_word_host adc_word_host_chk #(.DIV_W(DIV_W), .REQ_BITS(REQ_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .mosi_oe_o  (mosi_oe_o),
    .one_wire_q (ow_q),
    .div_q      (div_q)
);

// File: tb/adc_word_host_dev.sv
// Behavioural converter for the bench: records the request bits, drives
// ones while the request is sent, then B9..B0 and trailing zeros, and
// counts any overlap with the host drive on a shared line.
module adc_word_host_dev #(
    parameter int REQ_BITS = 8,
    parameter int RSP_BITS = 16
) (
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                mosi,
    input  logic                mosi_oe,
    input  logic                one_wire,
    input  logic [9:0]          sample,
    output logic                dev_bit,
    output logic [REQ_BITS-1:0] req,
    output int                  edges,
    output int                  clash
);
    int cnt = 0;

    initial begin
        dev_bit = 1'b1;
        req     = '0;
        edges   = 0;
        clash   = 0;
    end

    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            edges = cnt;
            cnt   = 0;
        end else begin
            if (cnt < REQ_BITS) req[REQ_BITS-1-cnt] = mosi;
            cnt = cnt + 1;
        end
    end

    always @(negedge sclk) begin
        if (cnt >= REQ_BITS && cnt < REQ_BITS + RSP_BITS) begin
            if (one_wire && mosi_oe) clash = clash + 1;
            dev_bit = (cnt - REQ_BITS < 10) ? sample[9 - (cnt - REQ_BITS)] : 1'b0;
        end else begin
            dev_bit = 1'b1;
        end
    end
endmodule

// File: tb/adc_word_host_tb.sv
`timescale 1ns/1ps
module adc_word_host_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       sgl = 1'b0, odd = 1'b0, msbf = 1'b0, ow = 1'b0;
    logic [7:0] div = 8'd0;
    logic       ow_l = 1'b0;
    logic [9:0] smp8 = '0, smp4 = '0;

    logic        busy8, valid8, cs8, sclk8, mosi8, oe8, dev8, miso8;
    logic        busy4, valid4, cs4, sclk4, mosi4, oe4, dev4, miso4;
    logic [15:0] res8, res4;
    logic [7:0]  req8, req4;
    int          edges8, edges4, clash8, clash4;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    assign miso8 = (ow_l && oe8) ? mosi8 : dev8;
    assign miso4 = (ow_l && oe4) ? mosi4 : dev4;

    adc_word_host #(.XFER_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sgl_i(sgl), .odd_i(odd),
        .msbf_i(msbf), .one_wire_i(ow), .div_i(div), .busy_o(busy8),
        .valid_o(valid8), .result_o(res8), .cs_n_o(cs8), .sclk_o(sclk8),
        .mosi_o(mosi8), .mosi_oe_o(oe8), .miso_i(miso8));

    adc_word_host #(.XFER_W(4)) u_dut_nib (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sgl_i(sgl), .odd_i(odd),
        .msbf_i(msbf), .one_wire_i(ow), .div_i(div), .busy_o(busy4),
        .valid_o(valid4), .result_o(res4), .cs_n_o(cs4), .sclk_o(sclk4),
        .mosi_o(mosi4), .mosi_oe_o(oe4), .miso_i(miso4));

    adc_word_host_dev #(.REQ_BITS(8), .RSP_BITS(16)) u_dev8 (
        .cs_n(cs8), .sclk(sclk8), .mosi(mosi8), .mosi_oe(oe8), .one_wire(ow_l),
        .sample(smp8), .dev_bit(dev8), .req(req8), .edges(edges8), .clash(clash8));

    adc_word_host_dev #(.REQ_BITS(8), .RSP_BITS(12)) u_dev4 (
        .cs_n(cs4), .sclk(sclk4), .mosi(mosi4), .mosi_oe(oe4), .one_wire(ow_l),
        .sample(smp4), .dev_bit(dev4), .req(req4), .edges(edges4), .clash(clash4));

    // Scoreboard queues
    logic [15:0] q_res8[$], q_res4[$];
    logic [7:0]  q_req8[$], q_req4[$];
    int          q_div[$];
    int          got8 = 0, got4 = 0, want8 = 0, want4 = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one start with its configuration and queues expectations.
    task automatic launch(input logic s, input logic o, input logic m, input logic w,
                          input int d, input logic [9:0] a8, input logic [9:0] a4);
        sgl = s; odd = o; msbf = m; ow = w; div = 8'(d); ow_l = w;
        smp8 = a8; smp4 = a4;
        start = 1'b1;
        q_res8.push_back({a8, 6'b0});
        q_res4.push_back({a4, 6'b0});
        q_req8.push_back({4'b0000, 1'b1, s, o, m});
        q_req4.push_back({4'b0000, 1'b1, s, o, m});
        q_div.push_back(d);
        want8++; want4++;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start (8-bit)", busy8, 1);
        chk("R9 busy after start (4-bit)", busy4, 1);
    endtask

    task automatic wait_done();
        while (got8 != want8 || got4 != want4) @(negedge clk);
    endtask

    // Monitor: per-cycle framing and per-frame comparisons.
    logic prev_cs8 = 1'b1, prev_sclk8 = 1'b0, prev_cs4 = 1'b1;
    int   rise8 = 0, rise4 = 0, hp = 0, hp_min = 0, hp_max = 0;
    int   oebad8 = 0, oebad4 = 0, idle_bad = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if ((cs8 && sclk8) || (cs4 && sclk4)) idle_bad++;
                if (!cs8) begin
                    if (prev_cs8) begin
                        rise8 = 0; hp = 0; hp_min = 1000; hp_max = 0; oebad8 = 0;
                    end else begin
                        hp++;
                    end
                    if (sclk8 && !prev_sclk8) rise8++;
                    if (sclk8 != prev_sclk8) begin
                        if (hp < hp_min) hp_min = hp;
                        if (hp > hp_max) hp_max = hp;
                        hp = 0;
                    end
                    if (oe8 !== ((ow_l && rise8 >= 8) ? 1'b0 : 1'b1)) oebad8++;
                end
                if (!cs4) begin
                    if (prev_cs4) begin rise4 = 0; oebad4 = 0; end
                    if (sclk4 && !prev_sclk4_q) rise4++;
                    if (oe4 !== ((ow_l && rise4 >= 8) ? 1'b0 : 1'b1)) oebad4++;
                end
                if (valid8) begin
                    if (q_res8.size() == 0) begin
                        chk("R9 unexpected valid (8-bit)", 1, 0);
                    end else begin
                        int d;
                        d = q_div.pop_front();
                        chk("R4 R5 result (8-bit)", res8, q_res8.pop_front());
                        chk("R2 R10 request bits (8-bit)", req8, q_req8.pop_front());
                        chk("R3 rising edges (8-bit)", edges8, 24);
                        chk("R8 shortest half period", hp_min, d + 1);
                        chk("R8 longest half period", hp_max, d + 1);
                        chk("R6 drive enable (8-bit)", oebad8, 0);
                        chk("R6 line overlap (8-bit)", clash8, 0);
                        chk("R9 busy low at valid (8-bit)", busy8, 0);
                    end
                    got8++;
                end
                if (valid4) begin
                    if (q_res4.size() == 0) begin
                        chk("R9 unexpected valid (4-bit)", 1, 0);
                    end else begin
                        chk("R4 R5 result (4-bit)", res4, q_res4.pop_front());
                        chk("R2 R10 request bits (4-bit)", req4, q_req4.pop_front());
                        chk("R3 rising edges (4-bit)", edges4, 20);
                        chk("R6 drive enable (4-bit)", oebad4, 0);
                        chk("R6 line overlap (4-bit)", clash4, 0);
                    end
                    got4++;
                end
            end
            prev_cs8 = cs8; prev_sclk8 = sclk8; prev_cs4 = cs4; prev_sclk4_q = sclk4;
        end
    end
    logic prev_sclk4_q = 1'b0;

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired before the sequence ended");
        finish_run();
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", cs8, 1);
        chk("R1 busy in reset", busy8, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n after reset (8-bit)", cs8, 1);
        chk("R1 sclk after reset", sclk8, 0);
        chk("R1 valid after reset", valid8 | valid4, 0);
        chk("R1 drive enable after reset", oe8 | oe4, 0);
        chk("R1 busy after reset (4-bit)", busy4, 0);

        // Four-wire, slow clock
        launch(1'b1, 1'b0, 1'b1, 1'b0, 1, 10'h2A5, 10'h15A);
        wait_done();
        // Single-wire, fastest clock, all-ones data
        launch(1'b0, 1'b1, 1'b0, 1'b1, 0, 10'h3FF, 10'h001);
        wait_done();
        // Zero data: request-phase ones must not leak in (R5)
        launch(1'b1, 1'b1, 1'b1, 1'b0, 2, 10'h000, 10'h200);
        wait_done();

        // Start while busy, with every configuration input changed (R9 R10)
        launch(1'b0, 1'b0, 1'b1, 1'b1, 3, 10'h1C3, 10'h0F0);
        repeat (20) @(negedge clk);
        sgl = 1'b1; odd = 1'b1; msbf = 1'b0; ow = 1'b0; div = 8'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy held through ignored start", busy8, 1);
        chk("R7 chip select held through ignored start", cs8, 0);
        wait_done();

        // Back-to-back: next start in the valid cycle (R11)
        launch(1'b1, 1'b0, 1'b0, 1'b0, 1, 10'h0AA, 10'h355);
        while (got4 != want4) @(negedge clk);
        do @(negedge clk); while (!valid8);
        launch(1'b0, 1'b1, 1'b1, 1'b1, 1, 10'h301, 10'h0C7);
        chk("R11 frame accepted in valid cycle", cs8, 0);
        wait_done();

        repeat (4) @(negedge clk);
        chk("R7 sclk low while deselected", idle_bad, 0);
        chk("R9 all expected results seen", q_res8.size() + q_res4.size(), 0);
        finish_run();
    end
endmodule